// File: doc/BRIEF.md
# Bypassable Valid-Ready Synchronous FIFO

This block is a single-clock queue placed between a producer and a consumer. Both sides use a valid/ready handshake, and each beat carries one payload word of `DATA_W` bits. Words come out in the same order they went in. An accepted word is never dropped and never sent twice.

The compile-time switch `PASS` selects one of two behaviours when the queue is empty. With `PASS` set, a word offered by the producer appears at the output in the same cycle. If the consumer takes it in that cycle, the word never enters storage. With `PASS` clear, every word is written to storage first, so it reaches the output no earlier than the next cycle.

`DEPTH` sets the number of entries and may be from 0 to 16. A depth of zero turns the block into a plain wire for valid, ready and data. Elaboration stops with an error if depth zero is combined with `PASS` clear, or if the depth is above 16.

Control is held in a small fill-level state machine with three states:
- `ST_EMPTY` holds no word.
- `ST_PART` holds some words but is not full.
- `ST_FULL` holds `DEPTH` words.

Its named transitions are:
- `FIRST_IN`: from EMPTY to PART, or straight to FULL when the depth is 1.
- `TOP_UP`: from PART to FULL.
- `LAST_OUT`: from PART to EMPTY.
- `MAKE_ROOM`: from FULL to PART, or to EMPTY when the depth is 1.

The occupancy count moves with the state and is used to recognise the PART boundaries.

Top module: `vr_bypass_fifo`

## Requirements
- R1: With `PASS`=1 and the queue empty, a word offered on `in_data` with `in_valid` high shows on `out_data` with `out_valid` high in the same cycle.
- R2: With `PASS`=0, `out_valid` stays low while the queue is empty. A word accepted in cycle n is first visible at the output in cycle n+1.
- R3: With `DEPTH`=0 (and `PASS`=1), `out_valid` equals `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready` in every cycle.
- R4: Words leave in acceptance order, including words that take the bypass, with none lost or duplicated under any pattern of stalls.
- R5: `in_ready` is low exactly while `DEPTH` words are held (for `DEPTH`>0).
- R6: While words are held and the consumer stalls, `out_valid` stays high and `out_data` stays unchanged into the next cycle.
- R7: An active-low synchronous reset empties the queue. After it, `out_valid` is low unless a word is being bypassed, and `in_ready` is high.
- R8: With `PASS`=1, a word offered while the queue is empty and `out_ready` is low is stored. It remains at the output in the following cycles until taken.
- R9: The default parameters give `PASS`=1 and `DEPTH`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Queue accepts the offered word |
| in_data | input | DATA_W | Producer word |
| out_valid | output | 1 | A word is presented to the consumer |
| out_ready | input | 1 | Consumer takes the presented word |
| out_data | output | DATA_W | Word presented to the consumer |

## Verification
The hardest case to reach from the ports is the moment the queue is full and the consumer takes a word while the producer keeps offering. In that cycle the ready signal is still low, so the offered word must not be lost; on the next cycle it must be accepted and queued behind the older words. The vector table drives the bypassable instance into that full state by holding the consumer off for two beats, then releases it with the producer still active. Random stall patterns on both a bypassing and a registered instance, checked against a queue model, repeat this many times. They also catch bypass words that arrive while stored words are draining.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_e;
endpackage

// File: rtl/vrf_store.sv
module vrf_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2,
    parameter int unsigned PTR_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= advance(wr_ptr);
            if (rd_en) rd_ptr <= advance(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_ptr] <= wr_data;
    end

    assign rd_data = slot[rd_ptr];
endmodule

// File: rtl/vrf_ctrl.sv
module vrf_ctrl
    import vrf_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic empty,
    output logic full
);
    fill_state_e state, state_nxt;
    logic [CNT_W-1:0] level;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    // occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n)          level <= '0;
        else if (push && !pop) level <= level + 1'b1;
        else if (pop && !push) level <= level - 1'b1;
    end

    // transitions: FIRST_IN, TOP_UP, LAST_OUT, MAKE_ROOM
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: if (push && !pop)
                state_nxt = (DEPTH == 1) ? ST_FULL : ST_PART;
            ST_PART: begin
                if (push && !pop && level == CNT_W'(DEPTH - 1))
                    state_nxt = ST_FULL;
                else if (pop && !push && level == CNT_W'(1))
                    state_nxt = ST_EMPTY;
            end
            ST_FULL: if (pop && !push)
                state_nxt = (DEPTH == 1) ? ST_EMPTY : ST_PART;
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        empty = (state == ST_EMPTY);
        full  = (state == ST_FULL);
    end
endmodule

// File: rtl/vr_bypass_fifo.sv
module vr_bypass_fifo #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2,
    parameter bit          PASS   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned SAFE_D = (DEPTH == 0) ? 1 : DEPTH;
    localparam int unsigned CNT_W  = $clog2(SAFE_D + 1);
    localparam int unsigned PTR_W  = (SAFE_D > 1) ? $clog2(SAFE_D) : 1;

    if (DEPTH == 0 && !PASS) begin : g_bad_cfg
        $error("vr_bypass_fifo: zero depth requires pass-through");
    end
    if (DEPTH > 16) begin : g_bad_depth
        $error("vr_bypass_fifo: depth above 16");
    end

    if (DEPTH == 0) begin : g_wire
        always_comb begin
            out_valid = in_valid;
            out_data  = in_data;
            in_ready  = out_ready;
        end
    end else begin : g_queue
        logic empty, full, bypass, push, pop;
        logic [DATA_W-1:0] head;

        vrf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push),
            .pop   (pop),
            .empty (empty),
            .full  (full)
        );

        vrf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (push),
            .wr_data (in_data),
            .rd_en   (pop),
            .rd_data (head)
        );

        always_comb begin
            in_ready = !full;
            if (PASS) begin
                bypass    = empty && in_valid && out_ready;
                out_valid = empty ? in_valid : 1'b1;
                out_data  = empty ? in_data : head;
            end else begin
                bypass    = 1'b0;
                out_valid = !empty;
                out_data  = head;
            end
            push = in_valid && !full && !bypass;
            pop  = !empty && out_ready;
        end
    end
endmodule

// File: rtl/vr_bypass_fifo_chk.sv
module vr_bypass_fifo_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 2,
    parameter bit          PASS   = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    logic [5:0] held;
    wire acc = in_valid && in_ready;
    wire dlv = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)        held <= '0;
        else if (acc && !dlv) held <= held + 1'b1;
        else if (dlv && !acc) held <= held - 1'b1;
    end

    // R1
    bypass_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (PASS && held == 0 && in_valid) |-> (out_valid && out_data == in_data));

    // R2
    no_early_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!PASS && held == 0) |-> !out_valid);

    // R3
    wire_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEPTH == 0) |-> (in_ready == out_ready && out_valid == in_valid));

    // R5
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEPTH != 0 && held == 6'(DEPTH)) |-> !in_ready);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held <= 6'(DEPTH));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && held != 0) |=> (out_valid && $stable(out_data)));

    // R7
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (PASS ? (out_valid == in_valid) : !out_valid));
endmodule

bind vr_bypass_fifo vr_bypass_fifo_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .PASS   (PASS)
) u_chk (.*);

// File: tb/tb_vr_bypass_fifo.sv
module tb_vr_bypass_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic a_iv = 0, a_or = 0, a_ir, a_ov; logic [7:0] a_d = 0, a_od;
    logic b_iv = 0, b_or = 0, b_ir, b_ov; logic [7:0] b_d = 0, b_od;
    logic c_iv = 0, c_or = 0, c_ir, c_ov; logic [7:0] c_d = 0, c_od;

    vr_bypass_fifo dut (.clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir),
        .in_data(a_d), .out_valid(a_ov), .out_ready(a_or), .out_data(a_od));
    vr_bypass_fifo #(.DATA_W(8), .DEPTH(3), .PASS(1'b0)) dut_reg (.clk(clk), .rst_n(rst_n),
        .in_valid(b_iv), .in_ready(b_ir), .in_data(b_d), .out_valid(b_ov),
        .out_ready(b_or), .out_data(b_od));
    vr_bypass_fifo #(.DATA_W(8), .DEPTH(0), .PASS(1'b1)) dut_wire (.clk(clk), .rst_n(rst_n),
        .in_valid(c_iv), .in_ready(c_ir), .in_data(c_d), .out_valid(c_ov),
        .out_ready(c_or), .out_data(c_od));

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // {in_valid, out_ready, in_data, exp_out_valid, exp_in_ready, exp_out_data}
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 1'b1, 8'hA1, 1'b1, 1'b1, 8'hA1},
        {1'b1, 1'b0, 8'hB2, 1'b1, 1'b1, 8'hB2},
        {1'b1, 1'b0, 8'hC3, 1'b1, 1'b1, 8'hB2},
        {1'b1, 1'b0, 8'hD4, 1'b1, 1'b0, 8'hB2},
        {1'b1, 1'b1, 8'hD4, 1'b1, 1'b0, 8'hB2},
        {1'b1, 1'b1, 8'hD4, 1'b1, 1'b1, 8'hC3},
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 8'hD4},
        {1'b0, 1'b1, 8'hEE, 1'b0, 1'b1, 8'hEE},
        {1'b1, 1'b1, 8'h5A, 1'b1, 1'b1, 8'h5A}
    };

    initial begin
        #(200000 * 4);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] qa[$], qb[$];
        int err_a, err_b, ord_a, ord_b, sent_a, got_a, sent_b, got_b;

        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check(a_ov == 1'b0, "R7 reset out_valid", a_ov, 0);
        rst_n = 1'b1;
        #1;
        check(b_ov == 1'b0 && b_ir == 1'b1, "R7 after reset", {b_ov, b_ir}, 1);

        // R9 default config (pass, depth 2), R1/R5/R6/R8 via vectors
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a_iv = VEC[i][19]; a_or = VEC[i][18]; a_d = VEC[i][17:10];
            #1;
            check(a_ov == VEC[i][9], $sformatf("R1/R8/R9 vec%0d out_valid", i), a_ov, VEC[i][9]);
            check(a_ir == VEC[i][8], $sformatf("R5/R9 vec%0d in_ready", i), a_ir, VEC[i][8]);
            check(a_od == VEC[i][7:0], $sformatf("R4/R6 vec%0d out_data", i), a_od, VEC[i][7:0]);
        end
        @(negedge clk); a_iv = 0; a_or = 0;

        // R2: registered latency
        @(negedge clk); b_iv = 1; b_or = 1; b_d = 8'h77; #1;
        check(b_ov == 1'b0, "R2 no same-cycle output", b_ov, 0);
        @(negedge clk); b_iv = 0; #1;
        check(b_ov == 1'b1 && b_od == 8'h77, "R2 next-cycle output", b_od, 8'h77);
        @(negedge clk); #1;
        check(b_ov == 1'b0, "R2 drained", b_ov, 0);

        // R5 depth 3 fill, then R7 reset mid-fill
        b_or = 0; b_iv = 1;
        for (int k = 0; k < 3; k++) begin
            b_d = 8'(8'h30 + k);
            #1 check(b_ir == 1'b1, "R5 room before full", b_ir, 1);
            @(negedge clk);
        end
        #1;
        check(b_ir == 1'b0, "R5 full blocks input", b_ir, 0);
        check(b_od == 8'h30, "R4 head is oldest", b_od, 8'h30);
        b_iv = 0; rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        check(b_ov == 1'b0 && b_ir == 1'b1, "R7 reset empties", {b_ov, b_ir}, 1);

        // R3 wire-through
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            c_iv = k[0]; c_or = k[1]; c_d = 8'(8'h90 + k); #1;
            check(c_ov == c_iv && c_ir == c_or && c_od == c_d, "R3 wire",
                  {c_ov, c_ir, c_od}, {c_iv, c_or, c_d});
        end

        // R4 random stalls with queue models, R1/R2 checked on the fly
        err_a = 0; err_b = 0; ord_a = 0; ord_b = 0;
        sent_a = 0; got_a = 0; sent_b = 0; got_b = 0;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            @(negedge clk);
            if (cyc < 1980) begin
                a_iv = $urandom_range(0, 1); a_or = ($urandom_range(0, 3) != 0);
                b_iv = $urandom_range(0, 1); b_or = $urandom_range(0, 1);
                a_d = 8'($urandom); b_d = 8'($urandom);
            end else begin
                a_iv = 0; b_iv = 0; a_or = 1; b_or = 1;
            end
            #1;
            if (qa.size() == 0 && a_iv && !(a_ov && a_od == a_d)) err_a++;
            if (qb.size() == 0 && b_ov) err_b++;
            if (a_iv && a_ir) begin qa.push_back(a_d); sent_a++; end
            if (a_ov && a_or) begin
                if (qa.size() == 0 || qa[0] != a_od) ord_a++;
                else void'(qa.pop_front());
                got_a++;
            end
            if (b_ov && b_or) begin
                if (qb.size() == 0 || qb[0] != b_od) ord_b++;
                else void'(qb.pop_front());
                got_b++;
            end
            if (b_iv && b_ir) begin qb.push_back(b_d); sent_b++; end
        end
        check(err_a == 0, "R1 random bypass", err_a, 0);
        check(err_b == 0, "R2 random empty output", err_b, 0);
        check(ord_a == 0 && sent_a == got_a, "R4 order/count pass", got_a, sent_a);
        check(ord_b == 0 && sent_b == got_b, "R4 order/count reg", got_b, sent_b);
        finish_run();
    end
endmodule